// File: doc/BRIEF.md
# Radix-4 Montgomery Modular Inverter

This block takes an operand `a` and an odd prime modulus `p`, both up to W bits wide, and returns `a^-1 * 2^W mod p`. That value is the inverse of `a` in the Montgomery domain with radix `2^W`. Elliptic-curve point arithmetic over a prime field uses it whenever a projective coordinate has to be brought back to affine form. The modulus is an input sampled at start, so one instance can serve any prime field up to W bits.

The computation has two phases. The first phase is an extended binary GCD. It starts from `u = p, v = a, r = 0, s = 1` and counts the total shift `k`. Each iteration can retire two bits instead of one. This happens when the value being halved has two trailing zeros, or when a nonzero odd-minus-odd difference is divisible by four. The first phase produces the almost-inverse `a^-1 * 2^k mod p`. The second phase moves this to exponent W. It halves modulo `p` once per iteration when `k > W`, and doubles modulo `p` once per iteration when `k < W`.

A caller presents `operand` and `modulus` with a one-cycle `start`. It then waits for the single-cycle `done`, and reads `result` and `error` in that cycle. If the operand shares a factor with the modulus, including a zero operand, `error` is raised together with `done`.

Top module: `montinv_radix4`

## Requirements
- R1: For an odd prime `p` and `0 < a < p`, the block ends with `error` = 0, `result < p` and `a * result ≡ 2^W (mod p)`. This holds for moduli narrower than W bits as well as full-width ones.
- R2: Edge operands give exact results. With `a = 1` the result is `2^W mod p`. With `a = p-1` the result is `p - (2^W mod p)`.
- R3: A zero operand still leads to `done`, with `error` = 1 and `result` = 0.
- R4: When `gcd(a, p) ≠ 1`, as happens with a composite modulus that shares a factor with `a`, the block ends with `error` = 1 and `result` = 0.
- R5: `done` is high for exactly one cycle. `result` and `error` keep their values after `done` until the next accepted `start`.
- R6: A `start` that arrives while an operation is in progress is ignored. The running operation completes with the operands sampled first, and no extra `done` follows.
- R7: Two bits can be retired in one step. This happens when the value being shifted has its two low bits at zero, or when the odd-minus-odd difference is nonzero and a multiple of four. For example, `a = 4, p = 7` raises `done` on the W+3rd rising edge, counting the edge that accepts `start` as the first.
- R8: `done` arrives no later than the 3W+4th rising edge after the accepting edge.
- R9: Reset is asynchronous active-low and its release is synchronised over two clock edges. Out of reset, `done` = 0, `error` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an inversion; sampled only when idle |
| operand | input | W | Value to invert, expected below the modulus |
| modulus | input | W | Odd modulus greater than 1 |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Inverse does not exist (zero operand or common factor) |
| result | output | W | `a^-1 * 2^W mod p`, zero on error |

## Verification
Some properties are checked by the embedded assertions on every cycle. These are: `done` never lasts two cycles, the latched modulus cannot change once an operation is running, and a step whose shifted value has two trailing zeros always advances `k` by exactly two. They also check that `k` stays within 2W, that the almost-inverse before reduction stays below `2p`, and that a completed result is below `p` or is zero under error. Other behaviour only the bench scenarios can show. This covers the algebraic correctness of `a * result ≡ 2^W` for random operands under several primes, including the exact edge values and the doubling path taken by narrow moduli. It also covers the error outcomes, the exact latency of the hand-worked radix-4 case, and the ignoring of a second `start`.

// File: rtl/minv_pkg.sv
package minv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOOP = 3'd1,
    ST_FIX  = 3'd2,
    ST_ADJ  = 3'd3,
    ST_DONE = 3'd4
  } minv_state_e;
endpackage

// File: rtl/minv_rst_sync.sv
module minv_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/minv_gcd_step.sv
// One iteration of the extended binary GCD, retiring one or two bits.
module minv_gcd_step #(
  parameter int unsigned W      = 256,
  parameter int unsigned RW     = W + 2,
  parameter bit          SHIFT2 = 1'b1
) (
  input  logic [W-1:0]  u_i,
  input  logic [W-1:0]  v_i,
  input  logic [RW-1:0] r_i,
  input  logic [RW-1:0] s_i,
  output logic [W-1:0]  u_o,
  output logic [W-1:0]  v_o,
  output logic [RW-1:0] r_o,
  output logic [RW-1:0] s_o,
  output logic [1:0]    kinc_o
);
  logic          u_gt_v;
  logic [W-1:0]  diff;
  logic [1:0]    sh_u, sh_v, sh_d;

  assign u_gt_v = (u_i > v_i);
  assign diff   = u_gt_v ? (u_i - v_i) : (v_i - u_i);

  // Shift amount choice: a parameter selects the radix.
  generate
    if (SHIFT2) begin : g_radix4
      assign sh_u = (u_i[1:0] == 2'b00) ? 2'd2 : 2'd1;
      assign sh_v = (v_i[1:0] == 2'b00) ? 2'd2 : 2'd1;
      // A zero difference takes a single shift so r stays below 2p.
      assign sh_d = ((diff[1:0] == 2'b00) && (diff != '0)) ? 2'd2 : 2'd1;
    end else begin : g_radix2
      assign sh_u = 2'd1;
      assign sh_v = 2'd1;
      assign sh_d = 2'd1;
    end
  endgenerate

  always_comb begin
    u_o    = u_i;
    v_o    = v_i;
    r_o    = r_i;
    s_o    = s_i;
    kinc_o = 2'd1;
    if (!u_i[0]) begin
      u_o    = u_i >> sh_u;
      s_o    = s_i << sh_u;
      kinc_o = sh_u;
    end else if (!v_i[0]) begin
      v_o    = v_i >> sh_v;
      r_o    = r_i << sh_v;
      kinc_o = sh_v;
    end else if (u_gt_v) begin
      u_o    = diff >> sh_d;
      r_o    = r_i + s_i;
      s_o    = s_i << sh_d;
      kinc_o = sh_d;
    end else begin
      v_o    = diff >> sh_d;
      s_o    = s_i + r_i;
      r_o    = r_i << sh_d;
      kinc_o = sh_d;
    end
  end
endmodule

// File: rtl/minv_adjust.sv
// One modular halving or doubling step of the exponent correction.
module minv_adjust #(
  parameter int unsigned W = 256
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] p_i,
  input  logic         halve_i,
  output logic [W-1:0] x_o
);
  logic [W:0] half_sum;
  logic [W:0] dbl;
  logic [W:0] dbl_red;

  assign half_sum = {1'b0, x_i} + (x_i[0] ? {1'b0, p_i} : '0);
  assign dbl      = {x_i, 1'b0};
  assign dbl_red  = (dbl >= {1'b0, p_i}) ? (dbl - {1'b0, p_i}) : dbl;

  always_comb begin
    if (halve_i) x_o = half_sum[W:1];
    else         x_o = dbl_red[W-1:0];
  end
endmodule

// File: rtl/montinv_radix4.sv
module montinv_radix4 #(
  parameter int unsigned W      = 256,
  parameter bit          SHIFT2 = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] modulus,
  output logic         done,
  output logic         error,
  output logic [W-1:0] result
);
  import minv_pkg::*;

  localparam int unsigned RW = W + 2;
  localparam int unsigned KW = $clog2(2 * W + 1) + 1;
  localparam logic [KW-1:0] W_K   = KW'(W);
  localparam logic [KW-1:0] KMAX  = KW'(2 * W);

  logic rst_n_s;

  minv_state_e    state_q, state_d;
  logic [W-1:0]   u_q, u_d, v_q, v_d, p_q, p_d, x_q, x_d;
  logic [RW-1:0]  r_q, r_d, s_q, s_d;
  logic [KW-1:0]  k_q, k_d, cnt_q, cnt_d;
  logic           halve_q, halve_d, err_q, err_d;

  logic [W-1:0]   u_s, v_s, x_a;
  logic [RW-1:0]  r_s, s_s;
  logic [1:0]     k_s;
  logic [RW-1:0]  p_ext, r_red, x_fix_w;

  minv_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_s)
  );

  minv_gcd_step #(.W(W), .RW(RW), .SHIFT2(SHIFT2)) u_step (
    .u_i    (u_q),
    .v_i    (v_q),
    .r_i    (r_q),
    .s_i    (s_q),
    .u_o    (u_s),
    .v_o    (v_s),
    .r_o    (r_s),
    .s_o    (s_s),
    .kinc_o (k_s)
  );

  minv_adjust #(.W(W)) u_adjust (
    .x_i     (x_q),
    .p_i     (p_q),
    .halve_i (halve_q),
    .x_o     (x_a)
  );

  // Almost-inverse reduction: r lies below 2p, so one subtraction suffices.
  assign p_ext   = {2'b00, p_q};
  assign r_red   = (r_q >= p_ext) ? (r_q - p_ext) : r_q;
  assign x_fix_w = p_ext - r_red;

  // Next-state process
  always_comb begin
    state_d = state_q;
    u_d     = u_q;
    v_d     = v_q;
    p_d     = p_q;
    r_d     = r_q;
    s_d     = s_q;
    k_d     = k_q;
    cnt_d   = cnt_q;
    halve_d = halve_q;
    err_d   = err_q;
    x_d     = x_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          u_d     = modulus;
          v_d     = operand;
          p_d     = modulus;
          r_d     = '0;
          s_d     = RW'(1);
          k_d     = '0;
          err_d   = 1'b0;
          state_d = ST_LOOP;
        end
      end
      ST_LOOP: begin
        if (v_q == '0) begin
          state_d = ST_FIX;
        end else begin
          u_d = u_s;
          v_d = v_s;
          r_d = r_s;
          s_d = s_s;
          k_d = k_q + KW'(k_s);
        end
      end
      ST_FIX: begin
        if (u_q != W'(1)) begin
          err_d   = 1'b1;
          x_d     = '0;
          state_d = ST_DONE;
        end else begin
          x_d = x_fix_w[W-1:0];
          if (k_q > W_K) begin
            cnt_d   = k_q - W_K;
            halve_d = 1'b1;
          end else begin
            cnt_d   = W_K - k_q;
            halve_d = 1'b0;
          end
          state_d = ST_ADJ;
        end
      end
      ST_ADJ: begin
        if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          x_d   = x_a;
          cnt_d = cnt_q - KW'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      u_q     <= '0;
      v_q     <= '0;
      p_q     <= '0;
      r_q     <= '0;
      s_q     <= '0;
      k_q     <= '0;
      cnt_q   <= '0;
      halve_q <= 1'b0;
      err_q   <= 1'b0;
      x_q     <= '0;
    end else begin
      state_q <= state_d;
      u_q     <= u_d;
      v_q     <= v_d;
      p_q     <= p_d;
      r_q     <= r_d;
      s_q     <= s_d;
      k_q     <= k_d;
      cnt_q   <= cnt_d;
      halve_q <= halve_d;
      err_q   <= err_d;
      x_q     <= x_d;
    end
  end

  assign done   = (state_q == ST_DONE);
  assign error  = err_q;
  assign result = x_q;

  // ---------------------------------------------------------------- checks
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  assert_modulus_held_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE) |=> $stable(p_q));

  assert_k_bound_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_LOOP) |-> (k_q <= KMAX));

  assert_almost_inv_range_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FIX && u_q == W'(1)) |-> (r_red < p_ext && x_fix_w[RW-1:W] == 2'b00));

  assert_result_range_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !error) |-> (result < p_q));

  assert_error_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && error) |-> (result == '0));

  generate
    if (SHIFT2) begin : g_chk_radix4
      assert_two_bit_step_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
        (state_q == ST_LOOP && v_q != '0 && u_q[1:0] == 2'b00)
          |=> (k_q == $past(k_q) + KW'(2)));
    end
  endgenerate
endmodule

// File: tb/montinv_radix4_bench.sv
module montinv_radix4_bench;
  localparam int unsigned W = 256;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] operand;
  logic [W-1:0] modulus;
  logic         done;
  logic         error;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] p;
    bit           exp_err;
    bit           exact;
    logic [W-1:0] val;
    string        tag;
  } item_t;

  item_t sb[$];
  logic         prev_done = 1'b0;
  logic [W-1:0] last_res;
  logic         last_err;

  montinv_radix4 #(.W(W)) u_montinv_radix4 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .modulus (modulus),
    .done    (done),
    .error   (error),
    .result  (result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ------------------------------------------------------------ model
  function automatic logic [W-1:0] mulmod(logic [W-1:0] x, logic [W-1:0] y,
                                          logic [W-1:0] m);
    logic [W+1:0] acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      acc = acc << 1;
      if (acc >= {2'b00, m}) acc = acc - {2'b00, m};
      if (y[i]) acc = acc + {2'b00, x};
      if (acc >= {2'b00, m}) acc = acc - {2'b00, m};
    end
    return acc[W-1:0];
  endfunction

  function automatic logic [W-1:0] pow2w(logic [W-1:0] m);
    logic [W:0] acc = 1;
    for (int i = 0; i < W; i++) begin
      acc = acc << 1;
      if (acc >= {1'b0, m}) acc = acc - {1'b0, m};
    end
    return acc[W-1:0];
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ------------------------------------------------------------ monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check(1'b0, "R5 done longer than one cycle", 1, 0);
      if (done) begin
        last_res = result;
        last_err = error;
        if (sb.size() == 0) begin
          check(1'b0, "R6 done with no pending operation", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (it.exp_err) begin
            check(error == 1'b1, {it.tag, " error flag"}, W'(error), 1);
            check(result == '0, {it.tag, " zero result"}, result, 0);
          end else begin
            logic [W-1:0] r2;
            r2 = pow2w(it.p);
            check(error == 1'b0, {it.tag, " error flag"}, W'(error), 0);
            check(result < it.p, {it.tag, " result below modulus"}, result, it.p);
            check(mulmod(it.a, result, it.p) == r2, {it.tag, " a*result mod p"},
                  mulmod(it.a, result, it.p), r2);
            if (it.exact) check(result == it.val, {it.tag, " exact value"}, result, it.val);
          end
        end
      end
      prev_done = done;
    end
  end

  // ------------------------------------------------------------ driver
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] p, bit exp_err, bit exact,
                        logic [W-1:0] val, string tag, int lat_exp);
    item_t it;
    int cyc = 0;
    it.a = a; it.p = p; it.exp_err = exp_err; it.exact = exact; it.val = val; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b1; operand = a; modulus = p;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
    check(cyc <= 3 * W + 4, "R8 latency bound", W'(cyc), W'(3 * W + 4));
    if (lat_exp > 0) check(cyc == lat_exp, "R7 radix-4 latency", W'(cyc), W'(lat_exp));
    repeat (4) @(negedge clk);
    check(result == last_res && error == last_err && !done, "R5 outputs held after done",
          result, last_res);
  endtask

  localparam logic [W-1:0] P_FULL = 256'd0 - 256'd189;
  localparam logic [W-1:0] P_255  = (256'd1 << 255) - 256'd19;
  localparam logic [W-1:0] P_127  = (256'd1 << 127) - 256'd1;
  localparam logic [W-1:0] P_16   = 256'd65521;
  localparam logic [W-1:0] P_3B   = 256'd7;

  function automatic logic [W-1:0] rnd_below(logic [W-1:0] p);
    logic [W-1:0] x;
    for (int i = 0; i < W / 32; i++) x[i*32 +: 32] = $urandom;
    x = x % p;
    if (x == '0) x = 1;
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] primes [5];
    logic [W-1:0] a2;
    primes[0] = P_FULL; primes[1] = P_255; primes[2] = P_127;
    primes[3] = P_16;   primes[4] = P_3B;
    start = 1'b0; operand = '0; modulus = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset values
    check(done == 1'b0, "R9 reset done", W'(done), 0);
    check(error == 1'b0, "R9 reset error", W'(error), 0);
    check(result == '0, "R9 reset result", result, 0);

    // R1: random operands under every modulus (wide ones halve, narrow ones double)
    foreach (primes[i]) begin
      for (int j = 0; j < 3; j++) run_op(rnd_below(primes[i]), primes[i], 0, 0, '0, "R1", 0);
    end

    // R2: edge operands 1 and p-1
    foreach (primes[i]) begin
      run_op(1, primes[i], 0, 1, pow2w(primes[i]), "R2 a=1", 0);
      run_op(primes[i] - 1, primes[i], 0, 1, primes[i] - pow2w(primes[i]), "R2 a=p-1", 0);
    end

    // R7: a=4, p=7 retires two bits in the first step; done on edge W+3
    run_op(4, P_3B, 0, 1, mulmod(2, pow2w(P_3B), P_3B), "R7 a=4 p=7", W + 3);

    // R3: zero operand
    run_op('0, P_127, 1, 0, '0, "R3 zero operand", 0);
    run_op('0, P_FULL, 1, 0, '0, "R3 zero operand full width", 0);

    // R4: common factor with a composite modulus
    run_op(6, 15, 1, 0, '0, "R4 gcd 3", 0);
    run_op(256'd21, 256'd91, 1, 0, '0, "R4 gcd 7", 0);

    // R6: second start during a run is ignored
    begin
      item_t it;
      logic [W-1:0] a1;
      a1 = rnd_below(P_255);
      a2 = rnd_below(P_16);
      it.a = a1; it.p = P_255; it.exp_err = 0; it.exact = 0; it.val = '0;
      it.tag = "R6 busy start ignored";
      sb.push_back(it);
      @(negedge clk);
      start = 1'b1; operand = a1; modulus = P_255;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1; operand = a2; modulus = P_16;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      repeat (30) @(negedge clk);
      check(sb.size() == 0 && !done, "R6 no extra done", W'(sb.size()), 0);
    end

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R1 scoreboard drained", W'(sb.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule